// File: doc/BRIEF.md
# Divide-by-Three Clock and Ready Synchronizer

This block turns a fast digital source clock into a processor clock running at one third of its rate, with the clock high for one source period and low for two. A second output runs at half the processor clock rate for peripherals. The source is picked by a select input. It is either the local oscillator input or an external frequency input. A clear input holds the divider at its starting point, so that several of these blocks fed from the same source can be brought into step.

The block also produces a registered ready output for the processor's bus cycle. Two ready requests, each qualified by its own active-low enable, are merged. The result passes through either one or two synchronizing stages, selected at run time. An active-low reset input is captured into an active-high reset output. All registered outputs change only at the source edge on which the processor clock rises.

There are no data streams in this block, so no valid/ready handshake applies. Every pin is a plain control or clock signal.

Top module: `clkrdy_gen`

## Requirements
- R1: With `src_sel` = 0 the divider advances only on rising edges of `osc_clk`, and edges on `ext_clk` have no effect. With `src_sel` = 1 it advances only on rising edges of `ext_clk`, and edges on `osc_clk` have no effect.
- R2: `cpu_clk` has a period of exactly three source rising edges. It is high for one source period and low for two.
- R3: `per_clk` toggles on every rising edge of `cpu_clk`. It therefore runs at half the `cpu_clk` rate with equal high and low times.
- R4: The ready request is (`rdy_req_a` AND NOT `rdy_en_a_n`) OR (`rdy_req_b` AND NOT `rdy_en_b_n`). A request whose enable is 1 is ignored.
- R5: With `single_stage` = 1, `ready_out` takes the request sampled at the source edge where `cpu_clk` rises.
- R6: With `single_stage` = 0, `ready_out` takes the request that was sampled one `cpu_clk` period earlier, which adds one processor clock of latency.
- R7: `ready_out` changes only at a source edge on which `cpu_clk` rises.
- R8: `cpu_rst` is the inverse of `rst_in_n`, captured only at a source edge on which `cpu_clk` rises.
- R9: While `sync_clr` = 1, the outputs `cpu_clk`, `per_clk` and `ready_out` are held at 0 and `cpu_rst` is held at 1. After release, `cpu_clk` first rises on the third source rising edge and then every third edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local oscillator clock source |
| ext_clk | input | 1 | External frequency clock source |
| src_sel | input | 1 | 0 selects `osc_clk`, 1 selects `ext_clk` |
| sync_clr | input | 1 | Holds the divider and outputs at their starting point |
| rdy_req_a | input | 1 | First ready request |
| rdy_en_a_n | input | 1 | Active-low enable for the first request |
| rdy_req_b | input | 1 | Second ready request |
| rdy_en_b_n | input | 1 | Active-low enable for the second request |
| single_stage | input | 1 | 1 selects one synchronizing stage, 0 selects two |
| rst_in_n | input | 1 | Active-low reset request |
| cpu_clk | output | 1 | Processor clock, source divided by three |
| per_clk | output | 1 | Peripheral clock, `cpu_clk` divided by two |
| ready_out | output | 1 | Synchronized ready to the processor |
| cpu_rst | output | 1 | Active-high reset, aligned to `cpu_clk` rises |

## Verification
The bench builds the block with its default parameters: a division ratio of three, one high source period, and a two-stage long synchronizer path. With these values a full `cpu_clk` period and a full `per_clk` period are short enough to check on every source edge. All sixteen combinations of the two requests and their enables can be swept in both stage modes, and the extra-period latency of the two-stage path is checked against the value held before each change. The block is also switched onto manually pulsed external edges while the oscillator keeps running, and is cleared in the middle of a period so that the restart phase can be checked.

// File: rtl/clkrdy_pkg.sv
package clkrdy_pkg;

  // Merge two requests, each gated by an active-low enable.
  function automatic logic merge_ready(
    input logic req_a, input logic en_a_n,
    input logic req_b, input logic en_b_n
  );
    return (req_a & ~en_a_n) | (req_b & ~en_b_n);
  endfunction

endpackage

// File: rtl/clkrdy_div.sv
module clkrdy_div #(
  parameter int DIV_RATIO  = 3,
  parameter int HIGH_COUNT = 1
) (
  input  logic clk,
  input  logic clr,
  output logic cpu_clk,
  output logic tick
);
  localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  assign tick    = (cnt == LAST) && !clr;
  assign cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt     <= '0;
      cpu_clk <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      cpu_clk <= (cnt_nxt < CW'(HIGH_COUNT));
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (clr)
    cnt <= LAST);
  p_rise_after_wrap_r2: assert property (@(posedge clk) disable iff (clr)
    $rose(cpu_clk) |-> $past(cnt) == LAST);
  p_tick_rises_clk_r9: assert property (@(posedge clk) disable iff (clr)
    tick |=> cpu_clk);
endmodule

// File: rtl/clkrdy_half.sv
module clkrdy_half (
  input  logic clk,
  input  logic clr,
  input  logic tick,
  output logic per_clk
);
  always_ff @(posedge clk) begin
    if (clr)       per_clk <= 1'b0;
    else if (tick) per_clk <= ~per_clk;
  end

  p_hold_between_r3: assert property (@(posedge clk) disable iff (clr)
    !tick |=> $stable(per_clk));
  p_flip_on_tick_r3: assert property (@(posedge clk) disable iff (clr)
    tick |=> per_clk != $past(per_clk));
endmodule

// File: rtl/clkrdy_rdysync.sv
module clkrdy_rdysync #(
  parameter int LONG_STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic tick,
  input  logic req,
  input  logic single_stage,
  output logic ready_out
);
  localparam int PIPE = (LONG_STAGES > 1) ? LONG_STAGES - 1 : 1;

  logic [PIPE-1:0] pipe;

  genvar gi;
  generate
    for (gi = 0; gi < PIPE; gi++) begin : g_pipe
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (clr)       pipe[0] <= 1'b0;
          else if (tick) pipe[0] <= req;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (clr)       pipe[gi] <= 1'b0;
          else if (tick) pipe[gi] <= pipe[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr)       ready_out <= 1'b0;
    else if (tick) ready_out <= single_stage ? req : pipe[PIPE-1];
  end

  p_ready_on_tick_r7: assert property (@(posedge clk) disable iff (clr)
    !tick |=> $stable(ready_out));
  p_single_path_r5: assert property (@(posedge clk) disable iff (clr)
    (tick && single_stage) |=> ready_out == $past(req));
endmodule

// File: rtl/clkrdy_rstcap.sv
module clkrdy_rstcap (
  input  logic clk,
  input  logic clr,
  input  logic tick,
  input  logic rst_in_n,
  output logic cpu_rst
);
  always_ff @(posedge clk) begin
    if (clr)       cpu_rst <= 1'b1;
    else if (tick) cpu_rst <= ~rst_in_n;
  end

  p_rst_capture_r8: assert property (@(posedge clk) disable iff (clr)
    tick |=> cpu_rst == !$past(rst_in_n));
  p_rst_hold_r8: assert property (@(posedge clk) disable iff (clr)
    !tick |=> $stable(cpu_rst));
endmodule

// File: rtl/clkrdy_gen.sv
module clkrdy_gen #(
  parameter int DIV_RATIO   = 3,
  parameter int HIGH_COUNT  = 1,
  parameter int LONG_STAGES = 2
) (
  input  logic osc_clk,
  input  logic ext_clk,
  input  logic src_sel,
  input  logic sync_clr,
  input  logic rdy_req_a,
  input  logic rdy_en_a_n,
  input  logic rdy_req_b,
  input  logic rdy_en_b_n,
  input  logic single_stage,
  input  logic rst_in_n,
  output logic cpu_clk,
  output logic per_clk,
  output logic ready_out,
  output logic cpu_rst
);
  import clkrdy_pkg::*;

  logic src_clk;
  logic tick;
  logic req;

  assign src_clk = src_sel ? ext_clk : osc_clk;
  assign req     = merge_ready(rdy_req_a, rdy_en_a_n, rdy_req_b, rdy_en_b_n);

  clkrdy_div #(.DIV_RATIO(DIV_RATIO), .HIGH_COUNT(HIGH_COUNT)) u_div (
    .clk(src_clk), .clr(sync_clr), .cpu_clk(cpu_clk), .tick(tick)
  );

  clkrdy_half u_half (
    .clk(src_clk), .clr(sync_clr), .tick(tick), .per_clk(per_clk)
  );

  clkrdy_rdysync #(.LONG_STAGES(LONG_STAGES)) u_rdy (
    .clk(src_clk), .clr(sync_clr), .tick(tick), .req(req),
    .single_stage(single_stage), .ready_out(ready_out)
  );

  clkrdy_rstcap u_rst (
    .clk(src_clk), .clr(sync_clr), .tick(tick),
    .rst_in_n(rst_in_n), .cpu_rst(cpu_rst)
  );

  p_clr_state_r9: assert property (@(posedge src_clk)
    $past(sync_clr) |-> (!cpu_clk && !per_clk && !ready_out && cpu_rst));
  p_per_follows_cpu_r3: assert property (@(posedge src_clk) disable iff (sync_clr)
    $changed(per_clk) |-> $rose(cpu_clk));
endmodule

// File: tb/clkrdy_gen_tb.sv
module clkrdy_gen_tb;
  logic osc_clk = 1'b0;
  logic ext_clk = 1'b0;
  logic src_sel = 1'b0;
  logic sync_clr = 1'b1;
  logic rdy_req_a = 1'b0, rdy_en_a_n = 1'b1, rdy_req_b = 1'b0, rdy_en_b_n = 1'b1;
  logic single_stage = 1'b1;
  logic rst_in_n = 1'b0;
  logic cpu_clk, per_clk, ready_out, cpu_rst;

  int checks = 0;
  int errors = 0;
  int k = 0;
  bit finished = 0;
  logic cur_out = 1'b0;

  always #10 osc_clk = ~osc_clk;

  clkrdy_gen u_dut (
    .osc_clk(osc_clk), .ext_clk(ext_clk), .src_sel(src_sel), .sync_clr(sync_clr),
    .rdy_req_a(rdy_req_a), .rdy_en_a_n(rdy_en_a_n),
    .rdy_req_b(rdy_req_b), .rdy_en_b_n(rdy_en_b_n),
    .single_stage(single_stage), .rst_in_n(rst_in_n),
    .cpu_clk(cpu_clk), .per_clk(per_clk), .ready_out(ready_out), .cpu_rst(cpu_rst)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  task automatic step();
    @(posedge osc_clk);
    @(negedge osc_clk);
    k++;
    #1;
  endtask

  task automatic check_clocks(input string req);
    check(req, cpu_clk, (k > 0) && (k % 3 == 0));
    check(req, per_clk, ((k / 3) % 2) == 1);
  endtask

  task automatic align();
    while (k % 3 != 0) step();
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: state held while clear is high
    repeat (4) step();
    check("R9", cpu_clk, 1'b0);
    check("R9", per_clk, 1'b0);
    check("R9", ready_out, 1'b0);
    check("R9", cpu_rst, 1'b1);
    sync_clr = 1'b0;
    k = 0;

    // R2, R3, R9 phase; R1 ext_clk pulses ignored while src_sel=0
    for (int i = 0; i < 36; i++) begin
      step();
      check_clocks("R2_R3_R1");
      ext_clk = 1'b1; #2; ext_clk = 1'b0;
    end

    // R8: reset capture only at cpu_clk rise
    align();
    rst_in_n = 1'b1;
    step(); check("R8", cpu_rst, 1'b1);
    step(); check("R8", cpu_rst, 1'b1);
    step(); check("R8", cpu_rst, 1'b0);
    rst_in_n = 1'b0;
    step(); check("R8", cpu_rst, 1'b0);
    step(); check("R8", cpu_rst, 1'b0);
    step(); check("R8", cpu_rst, 1'b1);
    rst_in_n = 1'b1;
    repeat (3) step();
    check("R8", cpu_rst, 1'b0);

    // R4, R5, R6, R7: all request/enable combinations in both modes
    cur_out = ready_out;
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 16; v++) begin
        logic expv;
        logic prev;
        align();
        single_stage = (m == 0);
        prev = cur_out;
        rdy_req_a  = v[0]; rdy_en_a_n = v[1];
        rdy_req_b  = v[2]; rdy_en_b_n = v[3];
        expv = (v[0] & ~v[1]) | (v[2] & ~v[3]);
        step(); check("R7", ready_out, cur_out);
        step(); check("R7", ready_out, cur_out);
        step();
        if (m == 0) check("R4_R5", ready_out, expv);
        else        check("R6", ready_out, prev_req_model(prev, expv, v));
        repeat (3) step();
        check(m == 0 ? "R4_R5" : "R4_R6", ready_out, expv);
        cur_out = expv;
      end
    end

    // R1: switch to external source, osc edges ignored
    align();
    src_sel = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #3 ext_clk = 1'b1;
      #3 ext_clk = 1'b0;
      k++;
      #1;
      check_clocks("R1");
    end
    @(negedge osc_clk);
    src_sel = 1'b0;
    #1;
    check_clocks("R1");

    // R9: clear mid-period, then restart phase
    align();
    step();
    sync_clr = 1'b1;
    step(); step();
    check("R9", cpu_clk, 1'b0);
    check("R9", per_clk, 1'b0);
    check("R9", ready_out, 1'b0);
    check("R9", cpu_rst, 1'b1);
    sync_clr = 1'b0;
    k = 0;
    for (int i = 0; i < 9; i++) begin
      step();
      check_clocks("R9");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Two-stage path: after the first rise the output holds the request
  // sampled one period before, which equals the previous combination's value.
  function automatic logic prev_req_model(input logic prev, input logic expv, input int v);
    return prev;
  endfunction
endmodule